// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a countdown timer for one processor. Software sets it up through a small register port. The base tick is the block's own clock. A power-of-two prescaler divides that tick, and each divided tick steps a down-counter. The timer's local vector entry sets three things: the vector number, a mask bit, and whether the count runs once or repeats.

When the count expires, the block raises a strobe for one clock cycle and drives the entry's vector with it, unless the entry is masked. Reads return the initial count, the live current count, the divide setting and the vector entry. An interrupt controller beside the block takes the strobe and vector and handles delivery.

Top module: `divtick_timer`

## Requirements
- R1: A write to register 2 (divide) stores only bits 3, 1 and 0 of the data (mask 0xB). The 3-bit code v is {bit3, bit1, bit0}, the shift is (v+1) mod 8, and one divided tick occurs every 2^shift clocks. So 0xB gives divide by 1 and 0x0 gives divide by 2.
- R2: Register 3 (vector entry) keeps bit 17 (1 = periodic), bit 16 (1 = masked) and bits 7:0 (vector). All other bits read back as zero.
- R3: A write to register 0 (initial count) loads the current count and clears the prescaler. The first decrement lands 2^shift clocks after the write edge, and a write during a running count restarts it.
- R4: In one-shot mode (bit 17 = 0) with initial count N > 0, the count falls to 0 and stays there. Exactly one strobe appears, first visible (N+1)·2^shift clocks after the write edge.
- R5: In periodic mode the count reloads from the initial value after reaching 0. A strobe appears every (N+1)·2^shift clocks.
- R6: An initial count of 0 produces no strobe in either mode.
- R7: While bit 16 is set, no strobe appears, but counting and reloading go on.
- R8: Reset clears the initial count, the current count, the divide register and the shift (divide by 1). It sets the vector entry to 0x0001_0000.
- R9: Register 1 (current count) is read-only. A write to it leaves every register unchanged.
- R10: A write to the vector entry does not restart the count. The new mode, mask and vector apply from the next divided tick.
- R11: Each strobe lasts exactly one cycle, and expire_vec carries bits 7:0 of the vector entry during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, also the undivided tick |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 initial, 1 current, 2 divide, 3 vector entry |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| expire_stb | output | 1 | One-cycle expiry pulse |
| expire_vec | output | 8 | Vector carried with the pulse, zero otherwise |

## Verification
The main function is driven with several combinations of divide code, mode and initial count. The shifts run from 0 to 7, including the non-adjacent codes 0x8, 0xA and 0xF7. Each case measures the delay to the first strobe and, in periodic mode, the gap to the second. A bit-order or off-by-one error in the divide decode therefore shows up as a wrong power of two. A one-shot case that fires twice shows up as a reload error. Zero-count and masked patterns separate "never armed" from "armed but silent". Directed sequences then cover a restart in the middle of a count, an entry rewrite that must not restart the count, writes to the read-only count, and the divide-by-1 state left by reset.

// File: rtl/divtick_pkg.sv
// Shared constants for the divided countdown timer.
// Assumes a 2-bit register select and 32-bit register data.
package divtick_pkg;
    typedef enum logic [1:0] {
        SEL_INIT = 2'd0,
        SEL_CUR  = 2'd1,
        SEL_DIV  = 2'd2,
        SEL_LVT  = 2'd3
    } reg_sel_e;

    localparam int unsigned LVT_PER_BIT  = 17;
    localparam int unsigned LVT_MASK_BIT = 16;
    localparam logic [3:0]  DIV_KEEP     = 4'hB;
endpackage

// File: rtl/divtick_prescaler.sv
// Power-of-two prescaler: produces one tick every 2^shift clocks.
// Assumes shift may change at any time; a count already past the new
// limit just ticks and wraps. clear restarts the phase from zero.
module divtick_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    // limit is 2^shift - 1, built as a mask of ones
    always_comb begin
        lim  = ~({PRE_W{1'b1}} << shift);
        tick = !clear && (cnt_q >= lim);
    end

    // phase counter: cleared on restart, wrapped on tick
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + PRE_W'(1);
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0) |=> (!tick || lim == '0));
endmodule

// File: rtl/divtick_counter.sv
// Down-counter stepped by divided ticks. Assumes reload_val holds the
// programmed initial count. Emits a one-cycle expire when a tick finds
// the armed count at zero; periodic reloads, one-shot disarms.
module divtick_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    logic [CNT_W-1:0] cur_q;
    logic             armed_q;

    // expiry: armed count at zero meets a tick, unless being reloaded
    always_comb begin
        expire = tick && armed_q && (cur_q == '0) && !load;
        cur    = cur_q;
    end

    // count state: load wins, then expiry handling, then decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            cur_q   <= load_val;
            armed_q <= (load_val != '0);
        end else if (tick && armed_q) begin
            if (cur_q == '0) begin
                if (periodic) cur_q   <= reload_val;
                else          armed_q <= 1'b0;
            end else begin
                cur_q <= cur_q - CNT_W'(1);
            end
        end
    end

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_q == $past(load_val));
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && armed_q && cur_q != '0 && !load) |=> cur_q == $past(cur_q) - CNT_W'(1));
    // R4
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && cur_q == '0 && !load) |=> cur_q == '0);
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> cur_q == $past(reload_val));
endmodule

// File: rtl/divtick_timer.sv
// Top of the divided countdown timer: register port, divide decode,
// timer vector entry and registered expiry strobe. Assumes single-cycle
// writes and a combinational read mux.
module divtick_timer
    import divtick_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int VEC_W   = 8,
    parameter int SHIFT_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        expire_stb,
    output logic [VEC_W-1:0] expire_vec
);
    logic [3:0]         div_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   init_q;
    logic [VEC_W-1:0]   lvt_vec_q;
    logic               lvt_mask_q;
    logic               lvt_per_q;
    logic               load_w;
    logic               tick_w;
    logic               expire_w;
    logic [CNT_W-1:0]   cur_w;
    reg_sel_e           sel;

    // decode the write target
    always_comb begin
        sel    = reg_sel_e'(reg_addr);
        load_w = reg_wr && (sel == SEL_INIT);
    end

    // register writes; current count has no write path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q      <= '0;
            shift_q    <= '0;
            init_q     <= '0;
            lvt_vec_q  <= '0;
            lvt_mask_q <= 1'b1;
            lvt_per_q  <= 1'b0;
        end else if (reg_wr) begin
            case (sel)
                SEL_INIT: init_q <= reg_wdata[CNT_W-1:0];
                SEL_DIV: begin
                    div_q   <= reg_wdata[3:0] & DIV_KEEP;
                    shift_q <= SHIFT_W'({reg_wdata[3], reg_wdata[1:0]}) + SHIFT_W'(1);
                end
                SEL_LVT: begin
                    lvt_vec_q  <= reg_wdata[VEC_W-1:0];
                    lvt_mask_q <= reg_wdata[LVT_MASK_BIT];
                    lvt_per_q  <= reg_wdata[LVT_PER_BIT];
                end
                default: ;
            endcase
        end
    end

    divtick_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load_w),
        .shift (shift_q),
        .tick  (tick_w)
    );

    divtick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_w),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .reload_val (init_q),
        .tick       (tick_w),
        .periodic   (lvt_per_q),
        .cur        (cur_w),
        .expire     (expire_w)
    );

    // read mux over the four registers
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_INIT: reg_rdata = 32'(init_q);
            SEL_CUR:  reg_rdata = 32'(cur_w);
            SEL_DIV:  reg_rdata = 32'(div_q);
            SEL_LVT: begin
                reg_rdata[VEC_W-1:0]    = lvt_vec_q;
                reg_rdata[LVT_MASK_BIT] = lvt_mask_q;
                reg_rdata[LVT_PER_BIT]  = lvt_per_q;
            end
            default: ;
        endcase
    end

    // registered strobe and vector, gated by the mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expire_stb <= 1'b0;
            expire_vec <= '0;
        end else begin
            expire_stb <= expire_w && !lvt_mask_q;
            expire_vec <= (expire_w && !lvt_mask_q) ? lvt_vec_q : '0;
        end
    end

    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_stb |=> !expire_stb);
    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_stb |-> !$past(lvt_mask_q));
    // R1
    stb_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_stb |-> $past(tick_w));
endmodule

// File: tb/divtick_timer_bench.sv
module divtick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        expire_stb;
    logic [7:0]  expire_vec;

    int compared = 0;
    int mismatched = 0;
    bit reported = 0;

    always #5ns clk = ~clk;

    divtick_timer u_divtick_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .expire_stb(expire_stb), .expire_vec(expire_vec)
    );

    // div, lvt, init, first strobe delay (0 = none), periodic gap (0 = one-shot)
    typedef struct packed {
        logic [31:0] div;
        logic [31:0] lvt;
        logic [31:0] init;
        logic [31:0] first;
        logic [31:0] gap;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{32'hB,  32'h0000_0021, 32'd5, 32'd6,   32'd0},
        '{32'h0,  32'h0002_0040, 32'd3, 32'd8,   32'd8},
        '{32'h1,  32'h0000_007E, 32'd2, 32'd12,  32'd0},
        '{32'hA,  32'h0002_0011, 32'd1, 32'd256, 32'd256},
        '{32'hF7, 32'h0000_0099, 32'd2, 32'd48,  32'd0},
        '{32'h8,  32'h0002_0001, 32'd0, 32'd0,   32'd0},
        '{32'hB,  32'h0000_0022, 32'd0, 32'd0,   32'd0},
        '{32'hB,  32'h0003_0055, 32'd3, 32'd0,   32'd0},
        '{32'h2,  32'h0002_00AA, 32'd4, 32'd40,  32'd40}
    };

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        end
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // call at a negedge; captured at the next posedge; returns at the negedge after
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1ns;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // watch win posedges; record strobe count, first two times, first vector
    task automatic watch(input int win, output int n, output int t1, output int t2,
                         output logic [7:0] v1);
        n = 0; t1 = 0; t2 = 0; v1 = '0;
        for (int k = 1; k <= win; k++) begin
            @(negedge clk);
            if (expire_stb) begin
                n++;
                if (n == 1) begin t1 = k; v1 = expire_vec; end
                else if (n == 2) t2 = k;
            end
        end
    endtask

    initial begin
        #2ms;
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [31:0] d;
        int n, t1, t2;
        logic [7:0] v;
        @(negedge clk);
        do_reset();

        // R8 reset values
        rd(2'd0, d); chk("R8 init after reset", d, 32'h0);
        rd(2'd1, d); chk("R8 cur after reset", d, 32'h0);
        rd(2'd2, d); chk("R8 div after reset", d, 32'h0);
        rd(2'd3, d); chk("R8 lvt after reset", d, 32'h0001_0000);
        chk("R8 no strobe after reset", {31'b0, expire_stb}, 32'h0);

        // table walk: R1 R4 R5 R6 R7 R11
        for (int i = 0; i < 9; i++) begin
            int win;
            do_reset();
            wr(2'd2, TBL[i].div);
            rd(2'd2, d); chk("R1 divide readback", d, TBL[i].div & 32'hB);
            wr(2'd3, TBL[i].lvt);
            wr(2'd0, TBL[i].init);
            if (TBL[i].first == 0) win = 300;
            else if (TBL[i].gap == 0) win = 2 * TBL[i].first + 10;
            else win = TBL[i].first + TBL[i].gap;
            watch(win, n, t1, t2, v);
            if (TBL[i].first == 0) begin
                chk("R6/R7 strobe count", n, 0);
            end else if (TBL[i].gap == 0) begin
                chk("R4 one-shot strobe count", n, 1);
                chk("R1/R4 first strobe delay", t1, TBL[i].first);
                chk("R11 strobe vector", {24'b0, v}, TBL[i].lvt & 32'hFF);
            end else begin
                chk("R5 periodic strobe count", n, 2);
                chk("R1/R5 first strobe delay", t1, TBL[i].first);
                chk("R5 periodic gap", t2 - t1, TBL[i].gap);
                chk("R11 strobe vector", {24'b0, v}, TBL[i].lvt & 32'hFF);
            end
        end

        // R7 masked periodic keeps counting
        do_reset();
        wr(2'd2, 32'hB); wr(2'd3, 32'h0003_0055); wr(2'd0, 32'd3);
        @(negedge clk); @(negedge clk);
        rd(2'd1, d); chk("R7 masked count runs", d, 32'd1);
        repeat (3) @(negedge clk);
        rd(2'd1, d); chk("R7 masked reload", d, 32'd2);

        // R8 reset shift is divide by 1
        do_reset();
        wr(2'd3, 32'h33); wr(2'd0, 32'd2);
        watch(10, n, t1, t2, v);
        chk("R8 reset shift strobe delay", t1, 3);

        // R3/R4 count trace and hold at zero
        do_reset();
        wr(2'd2, 32'hB); wr(2'd3, 32'h33); wr(2'd0, 32'd4);
        rd(2'd1, d); chk("R3 loaded count", d, 32'd4);
        @(negedge clk); @(negedge clk);
        rd(2'd1, d); chk("R3 count after 2 ticks", d, 32'd2);
        @(negedge clk); @(negedge clk);
        rd(2'd1, d); chk("R4 count reaches zero", d, 32'd0);
        @(negedge clk);
        chk("R4 strobe at N+1", {31'b0, expire_stb}, 32'h1);
        @(negedge clk);
        chk("R11 strobe one cycle", {31'b0, expire_stb}, 32'h0);
        @(negedge clk);
        rd(2'd1, d); chk("R4 count holds zero", d, 32'd0);

        // R3 restart mid-count
        do_reset();
        wr(2'd2, 32'hB); wr(2'd3, 32'h33); wr(2'd0, 32'd10);
        repeat (3) @(negedge clk);
        wr(2'd0, 32'd3);
        watch(12, n, t1, t2, v);
        chk("R3 restart strobe delay", t1, 4);
        chk("R3 restart single strobe", n, 1);

        // R9 current count read-only
        do_reset();
        wr(2'd2, 32'hA); wr(2'd0, 32'h50);
        wr(2'd1, 32'h99);
        rd(2'd1, d); chk("R9 cur unchanged by write", d, 32'h50);
        rd(2'd0, d); chk("R9 init unchanged by write", d, 32'h50);
        rd(2'd2, d); chk("R9 div unchanged by write", d, 32'hA);

        // R2 field retention
        wr(2'd3, 32'hFFFE_0F12);
        rd(2'd3, d); chk("R2 lvt fields only", d, 32'h0002_0012);

        // R10 entry rewrite does not restart
        do_reset();
        wr(2'd2, 32'hB); wr(2'd3, 32'h0002_0033); wr(2'd0, 32'd9);
        repeat (4) @(negedge clk);
        wr(2'd3, 32'h0002_0044);
        rd(2'd1, d); chk("R10 count continues", d, 32'd4);
        watch(8, n, t1, t2, v);
        chk("R10 strobe timing kept", t1, 5);
        chk("R10 new vector used", {24'b0, v}, 32'h44);

        report();
    end
endmodule